// File: doc/BRIEF.md
# Steerable watchdog timer

This block supervises a processor by counting time-base ticks toward a programmable limit. Software loads an 8-bit setup byte holding a steering bit, a 5-bit multiplier and a 2-bit resolution code. The limit is the multiplier times the chosen resolution. Either edge on an external kick input restarts the count, and so does any write of the setup byte.

When the count reaches the limit, a sticky flag is raised. The steering bit then decides what else happens. In interrupt mode an interrupt line is asserted and held until software rewrites the setup byte; writing zero also disarms the timer. In reset mode an active-low reset pulse of fixed length is emitted, the setup byte clears itself, and a one-cycle strobe tells a neighbouring block to clear its frequency-test enable. Reading the flags location clears the flag.

The time base is a single-cycle `tick_i` strobe. A resolution unit is `UNIT_TICKS` ticks long, and the reset pulse is `PULSE_TICKS` ticks long.

Top module: `steerable_wdog`

## Requirements
- R1: A write stores `cfg_wdata_i` in the setup byte, and `cfg_q_o` returns it. Bit 7 is the steering bit (0 = interrupt, 1 = reset pulse), bits 6..2 are the multiplier and bits 1..0 are the resolution code.
- R2: The timeout in units is the multiplier times 1, 4, 16 or 64 for resolution codes 00, 01, 10 and 11. One unit is `UNIT_TICKS` ticks. `wdf_o` rises right after the tick that completes the timeout, counting ticks taken after the last restart.
- R3: A multiplier of zero disables counting, so no expiry occurs however many ticks pass.
- R4: A rising or a falling edge on `kick_i` restarts the count. The edge is seen through a two-flop synchroniser, and the restart takes effect on the third clock edge after the input changes.
- R5: A setup write restarts the count. A write on the same edge as the completing tick wins, and no expiry occurs.
- R6: In interrupt mode, expiry raises `irq_o`. It stays high until the next setup write; flag reads and kicks leave it set.
- R7: In reset mode, expiry drives `rst_n_o` low from the expiry edge until `PULSE_TICKS` further ticks have passed. `irq_o` stays low.
- R8: A reset-mode expiry clears the setup byte to 00h, which disarms the timer, and pulses `ft_clr_o` high for exactly one cycle.
- R9: A strobe on `flag_rd_i` clears `wdf_o`. If an expiry falls in the same cycle, the flag is set instead.
- R10: After reset the setup byte is 00h, `wdf_o`, `irq_o` and `ft_clr_o` are 0, `rst_n_o` is 1, and the timer is disarmed.
- R11: After an expiry, counting stops until the next restart, so no second expiry follows without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up / power-down clear) |
| tick_i | input | 1 | One-cycle time-base strobe |
| cfg_we_i | input | 1 | Setup byte write strobe |
| cfg_wdata_i | input | 8 | Setup byte write data |
| flag_rd_i | input | 1 | Flags-read strobe, clears the flag |
| kick_i | input | 1 | Asynchronous kick input, both edges restart |
| cfg_q_o | output | 8 | Current setup byte |
| wdf_o | output | 1 | Sticky timeout flag |
| irq_o | output | 1 | Interrupt, active high |
| rst_n_o | output | 1 | Reset pulse, active low |
| ft_clr_o | output | 1 | One-cycle strobe to clear the frequency-test enable |

## Verification
Two pairs of events can land on the same clock edge. The first is a setup write on the edge of the completing tick. The second is a flags read on the edge of the expiry. The bench places each one on the posedge that carries the terminal tick by counting clock phases from a known tick. It then judges the write collision by a missing flag followed by a fresh full-length timeout, and the read collision by a flag that is still set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       steer;
    logic [4:0] mult;
    logic [1:0] res;
  } wd_cfg_t;

  localparam int unsigned MAX_UNITS = 31 * 64;

  // units per resolution step: 1, 4, 16, 64
  function automatic int unsigned res_units(input logic [1:0] code);
    return 32'd1 << (2 * code);
  endfunction

  function automatic int unsigned timeout_units(input wd_cfg_t c);
    return int'(c.mult) * res_units(c.res);
  endfunction

endpackage

// File: rtl/wdog_edge_sync.sv
module wdog_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_i;
  end

  for (genvar g = 1; g <= STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign edge_o = chain[STAGES-1] ^ chain[STAGES];

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int UNIT_TICKS = 62,
  parameter int CW         = 17
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    restart_i,
  input  wd_cfg_t cfg_i,
  output logic    expire_o
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;
  logic          halted;
  logic          armed;

  assign target   = CW'(timeout_units(cfg_i) * UNIT_TICKS);
  assign armed    = (cfg_i.mult != 5'd0) && !halted;
  assign expire_o = tick_i && armed && !restart_i && (cnt == target - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      halted <= 1'b0;
    end else if (restart_i) begin
      cnt    <= '0;
      halted <= 1'b0;
    end else if (expire_o) begin
      cnt    <= '0;
      halted <= 1'b1;
    end else if (tick_i && armed) begin
      cnt    <= cnt + CW'(1);
    end
  end

  // R3: zero multiplier never expires
  a_r3_zero_mult: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.mult == 5'd0) |-> !expire_o);
  // R4/R5: a restart clears the count
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt == '0));
  // R11: after expiry no further expiry until restart
  a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !restart_i) |=> !expire_o);

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic start_i,
  output logic rst_n_o
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     left <= '0;
    else if (start_i)               left <= PW'(PULSE_TICKS);
    else if (tick_i && left != '0)  left <= left - PW'(1);
  end

  assign rst_n_o = (left == '0);

  // R7: pulse only begins from a start request
  a_r7_pulse_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_n_o) |-> $past(start_i));
  // R7: without a tick the pulse does not end
  a_r7_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_n_o && !tick_i) |=> !rst_n_o);

endmodule

// File: rtl/steerable_wdog.sv
module steerable_wdog
  import wdog_pkg::*;
#(
  parameter int UNIT_TICKS  = 62,
  parameter int PULSE_TICKS = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  input  logic       flag_rd_i,
  input  logic       kick_i,
  output logic [7:0] cfg_q_o,
  output logic       wdf_o,
  output logic       irq_o,
  output logic       rst_n_o,
  output logic       ft_clr_o
);
  localparam int CW = $clog2(MAX_UNITS * UNIT_TICKS + 1);

  wd_cfg_t cfg;
  logic    kick_edge;
  logic    restart;
  logic    expire;
  logic    expire_rst;
  logic    expire_irq;

  wdog_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(kick_i), .edge_o(kick_edge)
  );

  assign restart = cfg_we_i | kick_edge;

  wdog_timer #(.UNIT_TICKS(UNIT_TICKS), .CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .restart_i(restart),
    .cfg_i(cfg), .expire_o(expire)
  );

  assign expire_rst = expire &&  cfg.steer;
  assign expire_irq = expire && !cfg.steer;

  wdog_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(expire_rst),
    .rst_n_o(rst_n_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      wdf_o    <= 1'b0;
      irq_o    <= 1'b0;
      ft_clr_o <= 1'b0;
    end else begin
      ft_clr_o <= expire_rst;
      if (cfg_we_i)        cfg <= wd_cfg_t'(cfg_wdata_i);
      else if (expire_rst) cfg <= '0;
      if (expire)          wdf_o <= 1'b1;
      else if (flag_rd_i)  wdf_o <= 1'b0;
      if (cfg_we_i)        irq_o <= 1'b0;
      else if (expire_irq) irq_o <= 1'b1;
    end
  end

  assign cfg_q_o = cfg;

  // R9: expiry always leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> wdf_o);
  // R6: interrupt holds until a setup write
  a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cfg_we_i) |=> irq_o);
  // R8: the clear strobe comes with an emptied setup byte
  a_r8_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr_o |-> (cfg_q_o == 8'h00));
  // R8: the clear strobe is a single cycle
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    ft_clr_o |=> !ft_clr_o);
  // R7: reset-mode expiry never raises the interrupt
  a_r7_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_rst && !irq_o) |=> !irq_o);

endmodule

// File: tb/steerable_wdog_bench.sv
module steerable_wdog_bench;
  localparam int UT = 2;
  localparam int PT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic rd = 1'b0;
  logic kick = 1'b0;
  logic [7:0] cfg_q;
  logic wdf, irq, rstn_out, ftclr;
  logic [1:0] tph = 2'd0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  steerable_wdog #(.UNIT_TICKS(UT), .PULSE_TICKS(PT)) u_steerable_wdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .flag_rd_i(rd), .kick_i(kick), .cfg_q_o(cfg_q), .wdf_o(wdf), .irq_o(irq),
    .rst_n_o(rstn_out), .ft_clr_o(ftclr)
  );

  always #4 clk = ~clk;

  // tick every fourth clock
  always @(negedge clk) begin
    tph  <= tph + 2'd1;
    tick <= (tph == 2'd2);
  end

  // {setup byte, expected ticks to expiry}
  localparam logic [15:0] VEC [6] = '{
    {8'h04, 8'd2},    // mult 1, res 00
    {8'h0E, 8'd96},   // mult 3, res 10
    {8'h05, 8'd8},    // mult 1, res 01
    {8'h07, 8'd128},  // mult 1, res 11
    {8'h7C, 8'd62},   // mult 31, res 00
    {8'h09, 8'd16}    // mult 2, res 01
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      do @(posedge clk); while (tick !== 1'b1);
    end
    #1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic flag_read();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(cfg_q == 8'h00 && !wdf && !irq && rstn_out && !ftclr, "R10 reset state",
        {cfg_q, wdf, irq, rstn_out, ftclr}, 2);
    wait_ticks(20);
    chk(!wdf, "R10 disarmed after reset", wdf, 0);

    // table walk: R1, R2, R6, R9, R11
    for (int i = 0; i < 6; i++) begin
      logic [7:0] c;
      int n;
      c = VEC[i][15:8];
      n = int'(VEC[i][7:0]);
      chk(n == int'(c[6:2]) * (1 << (2 * c[1:0])) * UT, "R2 table consistency", n, 0);
      wr(c);
      chk(cfg_q == c, "R1 readback", cfg_q, c);
      wait_ticks(n - 1);
      chk(!wdf && !irq, "R2 no early expiry", wdf, 0);
      wait_ticks(1);
      chk(wdf && irq, "R2 expiry at limit / R6 irq", {wdf, irq}, 3);
      flag_read();
      chk(!wdf, "R9 flag read clears", wdf, 0);
      chk(irq, "R6 irq survives flag read", irq, 1);
      wait_ticks(n);
      chk(!wdf, "R11 halted after expiry", wdf, 0);
      wr(8'h00);
      chk(!irq, "R6 write clears irq", irq, 0);
    end

    // R4 kick rising and falling
    wr(8'h08);
    wait_ticks(3);
    kick = 1'b1;
    wait_ticks(3);
    chk(!wdf, "R4 rising kick restarts", wdf, 0);
    wait_ticks(1);
    chk(wdf, "R4 expiry after rising kick", wdf, 1);
    flag_read();
    wr(8'h08);
    wait_ticks(3);
    kick = 1'b0;
    wait_ticks(3);
    chk(!wdf, "R4 falling kick restarts", wdf, 0);
    wait_ticks(1);
    chk(wdf && irq, "R4 expiry after falling kick", {wdf, irq}, 3);
    kick = 1'b1;
    repeat (6) @(negedge clk);
    chk(irq, "R6 kick leaves irq set", irq, 1);
    wr(8'h00);
    flag_read();

    // R5 write on the terminal tick
    wr(8'h04);
    wait_ticks(1);
    repeat (3) @(posedge clk);
    @(negedge clk); we = 1'b1; wdata = 8'h04;
    @(negedge clk); we = 1'b0;
    chk(!wdf && !irq, "R5 write beats expiry", {wdf, irq}, 0);
    wait_ticks(1);
    chk(!wdf, "R5 restart full length", wdf, 0);
    wait_ticks(1);
    chk(wdf, "R5 expiry after restart", wdf, 1);
    wr(8'h00);
    flag_read();

    // R9 flag read on the expiry edge
    wr(8'h04);
    wait_ticks(1);
    repeat (3) @(posedge clk);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    chk(wdf, "R9 expiry beats flag read", wdf, 1);
    wr(8'h00);
    flag_read();

    // R3 zero multiplier
    wr(8'h03);
    wait_ticks(140);
    chk(!wdf && !irq, "R3 zero multiplier disarmed", wdf, 0);

    // R7/R8 reset mode
    wr(8'h84);
    wait_ticks(1);
    chk(rstn_out && !wdf, "R7 no early pulse", rstn_out, 1);
    wait_ticks(1);
    chk(wdf && !irq && !rstn_out, "R7 pulse starts, no irq", {wdf, irq, rstn_out}, 4);
    chk(cfg_q == 8'h00, "R8 setup cleared", cfg_q, 0);
    chk(ftclr, "R8 strobe high", ftclr, 1);
    @(posedge clk); #1;
    chk(!ftclr, "R8 strobe one cycle", ftclr, 0);
    wait_ticks(PT - 1);
    chk(!rstn_out, "R7 pulse still low", rstn_out, 0);
    wait_ticks(1);
    chk(rstn_out, "R7 pulse ends", rstn_out, 1);
    flag_read();
    wait_ticks(20);
    chk(!wdf && rstn_out, "R8 disarmed after reset-mode expiry", wdf, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule